// File: doc/BRIEF.md
# Console Transmit Interrupt Request Latch

This block produces the interrupt request of a serial console transmit channel. It watches the product of the channel's interrupt enable bit and its device ready flag. The request is raised on a 0-to-1 change of that product, not on its level. Once raised, the request is held until the processor takes the interrupt, which it signals with a one-cycle acknowledge pulse that has already been qualified for this channel. A bus-wide I/O reset also removes the request, so a request left over from before a halt cannot reach the next boot.

The request is presented together with a fixed priority-level code. A build-time parameter selects one of two clearing policies. In the default policy a request stays pending until it is acknowledged or reset. The alternative policy withdraws a pending request that has not been taken as soon as enable AND ready falls to 0. A request that simply follows the level of enable AND ready is not offered, because it keeps firing while the transmitter sits idle and ready and locks the processor in its interrupt handler.

Top module: `console_irq_latch`

## Requirements
- R1: On a clock where enable AND ready is 1 and was 0 on the previous clock, `irq_pending` is 1 after that clock edge.
- R2: An `ack` pulse clears `irq_pending` on the next edge, even when enable and ready both stay 1.
- R3: `irq_pending` never goes from 0 to 1 unless a new rising edge of enable AND ready occurs. After an acknowledge, a steady high condition raises no second request.
- R4: `io_reset` clears `irq_pending` on the next edge and wins over a rising edge in the same clock. It does not clear the edge history, so a condition that stays high afterwards raises no request.
- R5: With `WITHDRAW_ON_FALL` = 0, dropping enable or ready leaves a pending request in place.
- R6: With `WITHDRAW_ON_FALL` = 1, a pending request is cleared on the next edge of any clock in which enable AND ready is 0.
- R7: `irq_level` equals `LEVEL_CODE` (default 0x14) while `irq_pending` is 1, and 0 otherwise.
- R8: A rising edge and an `ack` in the same clock leave `irq_pending` at 1.
- R9: After `rst`, `irq_pending` and `irq_level` are 0. The edge history resets to 0, so a condition already high when reset ends raises one request on the first clock it is seen.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| io_reset | input | 1 | Bus I/O reset; clears the pending request |
| tx_enable | input | 1 | Interrupt enable bit of the channel |
| tx_ready | input | 1 | Transmitter ready flag |
| ack | input | 1 | One-cycle interrupt acknowledge for this channel |
| irq_pending | output | 1 | Pending interrupt request |
| irq_level | output | LEVEL_W | Priority code, valid while the request is pending |

## Verification
The bench builds two copies side by side from the same stimulus. One uses `WITHDRAW_ON_FALL` = 0 and the other uses 1, both with the default 5-bit level code 0x14. Driving them together shows in a single run that one input trace gives different results under the two policies: a request survives a falling condition in one copy and is withdrawn in the other. Both copies see the same edge, acknowledge and reset priorities, which are otherwise identical between them.

// File: rtl/console_irq_pkg.sv
package console_irq_pkg;

    typedef enum logic {
        CLR_HOLD     = 1'b0,
        CLR_WITHDRAW = 1'b1
    } clear_policy_e;

    typedef struct packed {
        logic set_req;
        logic clr_ack;
        logic clr_bus;
        logic clr_fall;
    } req_ctrl_t;

    function automatic clear_policy_e policy_from_param(input int unsigned withdraw);
        return (withdraw != 0) ? CLR_WITHDRAW : CLR_HOLD;
    endfunction

    function automatic req_ctrl_t decode_ctrl(
        input clear_policy_e policy,
        input logic          rise,
        input logic          cond,
        input logic          ack,
        input logic          bus_rst
    );
        req_ctrl_t c;
        c.set_req  = rise;
        c.clr_ack  = ack;
        c.clr_bus  = bus_rst;
        c.clr_fall = (policy == CLR_WITHDRAW) && !cond;
        return c;
    endfunction

    function automatic logic next_request(input logic cur, input req_ctrl_t c);
        logic n;
        if (c.clr_bus)       n = 1'b0;
        else if (c.set_req)  n = 1'b1;
        else if (c.clr_ack)  n = 1'b0;
        else if (c.clr_fall) n = 1'b0;
        else                 n = cur;
        return n;
    endfunction

endpackage

// File: rtl/cond_edge_detect.sv
module cond_edge_detect (
    input  logic clk,
    input  logic rst,
    input  logic cond,
    output logic rise
);
    logic cond_q;

    always_ff @(posedge clk) begin
        if (rst) cond_q <= 1'b0;
        else     cond_q <= cond;
    end

    assign rise = cond && !cond_q;

    // R1
    rise_needs_low_before_chk: assert property (@(posedge clk) disable iff (rst)
        rise |=> cond_q);

endmodule

// File: rtl/irq_req_latch.sv
module irq_req_latch
    import console_irq_pkg::*;
#(
    parameter int unsigned WITHDRAW_ON_FALL = 0
) (
    input  logic clk,
    input  logic rst,
    input  logic io_reset,
    input  logic cond,
    input  logic rise,
    input  logic ack,
    output logic pending
);
    localparam clear_policy_e POLICY = policy_from_param(WITHDRAW_ON_FALL);

    req_ctrl_t ctrl;

    always_comb ctrl = decode_ctrl(POLICY, rise, cond, ack, io_reset);

    always_ff @(posedge clk) begin
        if (rst) pending <= 1'b0;
        else     pending <= next_request(pending, ctrl);
    end

    // R1
    edge_sets_req_chk: assert property (@(posedge clk) disable iff (rst)
        (rise && !io_reset) |=> pending);

    // R2
    ack_clears_req_chk: assert property (@(posedge clk) disable iff (rst)
        (ack && !rise) |=> !pending);

    // R3
    no_spont_req_chk: assert property (@(posedge clk) disable iff (rst)
        (!pending && !rise) |=> !pending);

    // R4
    bus_reset_clears_chk: assert property (@(posedge clk) disable iff (rst)
        io_reset |=> !pending);

    // R8
    edge_beats_ack_chk: assert property (@(posedge clk) disable iff (rst)
        (rise && ack && !io_reset) |=> pending);

    generate
        if (POLICY == CLR_WITHDRAW) begin : g_withdraw
            // R6
            fall_withdraws_chk: assert property (@(posedge clk) disable iff (rst)
                !cond |=> !pending);
        end else begin : g_hold
            // R5
            fall_keeps_req_chk: assert property (@(posedge clk) disable iff (rst)
                (pending && !ack && !io_reset) |=> pending);
        end
    endgenerate

endmodule

// File: rtl/console_irq_latch.sv
module console_irq_latch #(
    parameter int unsigned WITHDRAW_ON_FALL = 0,
    parameter int unsigned LEVEL_W          = 5,
    parameter logic [LEVEL_W-1:0] LEVEL_CODE = LEVEL_W'(20)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               io_reset,
    input  logic               tx_enable,
    input  logic               tx_ready,
    input  logic               ack,
    output logic               irq_pending,
    output logic [LEVEL_W-1:0] irq_level
);
    logic cond;
    logic rise;

    assign cond = tx_enable && tx_ready;

    cond_edge_detect i_edge (
        .clk  (clk),
        .rst  (rst),
        .cond (cond),
        .rise (rise)
    );

    irq_req_latch #(
        .WITHDRAW_ON_FALL (WITHDRAW_ON_FALL)
    ) i_latch (
        .clk      (clk),
        .rst      (rst),
        .io_reset (io_reset),
        .cond     (cond),
        .rise     (rise),
        .ack      (ack),
        .pending  (irq_pending)
    );

    assign irq_level = irq_pending ? LEVEL_CODE : '0;

    // R9
    reset_idle_chk: assert property (@(posedge clk)
        rst |=> !irq_pending);

endmodule

// File: tb/test_console_irq_latch.sv
`timescale 1ns/1ps
module test_console_irq_latch;
    localparam int LW = 5;
    localparam logic [LW-1:0] LVL = 5'h14;

    logic clk = 1'b0;
    logic rst, io_reset, tx_enable, tx_ready, ack;
    logic pend_h, pend_w;
    logic [LW-1:0] lvl_h, lvl_w;

    int checks = 0;
    int failures = 0;
    logic exp_h, exp_w, prev_c;

    always #4 clk = ~clk;

    console_irq_latch #(.WITHDRAW_ON_FALL(0)) i_console_irq_latch (
        .clk(clk), .rst(rst), .io_reset(io_reset), .tx_enable(tx_enable),
        .tx_ready(tx_ready), .ack(ack), .irq_pending(pend_h), .irq_level(lvl_h));

    console_irq_latch #(.WITHDRAW_ON_FALL(1)) i_console_irq_latch_w (
        .clk(clk), .rst(rst), .io_reset(io_reset), .tx_enable(tx_enable),
        .tx_ready(tx_ready), .ack(ack), .irq_pending(pend_w), .irq_level(lvl_w));

    function automatic logic model_next(input logic withdraw, input logic cur,
        input logic prev, input logic c, input logic a, input logic ior, input logic r);
        if (r || ior)       return 1'b0;
        if (c && !prev)     return 1'b1;
        if (a)              return 1'b0;
        if (withdraw && !c) return 1'b0;
        return cur;
    endfunction

    function automatic string pick_tag(input logic withdraw, input logic prev,
        input logic c, input logic a, input logic ior, input logic r);
        if (r)              return "R9";
        if (ior)            return "R4";
        if (c && !prev && a) return "R8";
        if (c && !prev)     return "R1";
        if (a)              return "R2";
        if (!c)             return withdraw ? "R6" : "R5";
        return "R3";
    endfunction

    task automatic check_bit(input string tag, input string who, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s pending actual=%0b expected=%0b", tag, who, act, exp);
        end
    endtask

    task automatic check_lvl(input string who, input logic [LW-1:0] act, input logic p);
        logic [LW-1:0] e;
        e = p ? LVL : '0;
        checks++;
        if (act !== e) begin
            failures++;
            $display("FAIL R7 %s level actual=%0h expected=%0h", who, act, e);
        end
    endtask

    task automatic step(input logic r, input logic ior, input logic en,
                        input logic rdy, input logic a);
        string th, tw;
        logic c;
        rst = r; io_reset = ior; tx_enable = en; tx_ready = rdy; ack = a;
        c = en && rdy;
        @(posedge clk);
        th = pick_tag(1'b0, prev_c, c, a, ior, r);
        tw = pick_tag(1'b1, prev_c, c, a, ior, r);
        exp_h = model_next(1'b0, exp_h, prev_c, c, a, ior, r);
        exp_w = model_next(1'b1, exp_w, prev_c, c, a, ior, r);
        prev_c = r ? 1'b0 : c;
        @(negedge clk);
        check_bit(th, "hold", pend_h, exp_h);
        check_bit(tw, "withdraw", pend_w, exp_w);
        check_lvl("hold", lvl_h, exp_h);
        check_lvl("withdraw", lvl_w, exp_w);
    endtask

    initial begin
        #(8 * 100000);
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        int unsigned seed;
        seed = 32'd1234;
        void'($urandom(seed));
        exp_h = 1'b0; exp_w = 1'b0; prev_c = 1'b0;
        rst = 1'b1; io_reset = 0; tx_enable = 0; tx_ready = 0; ack = 0;
        @(negedge clk);
        // R9: reset state, condition already high at reset release
        step(1, 0, 1, 1, 0);
        step(0, 0, 1, 1, 0);   // R9/R1 one request
        step(0, 0, 1, 1, 0);   // R3 held
        step(0, 0, 1, 1, 1);   // R2 ack with condition high
        step(0, 0, 1, 1, 0);   // R3 no re-request
        step(0, 0, 1, 1, 0);
        step(0, 0, 0, 1, 0);   // fall
        step(0, 0, 1, 1, 0);   // R1 new edge
        step(0, 0, 1, 0, 0);   // R5 kept / R6 withdrawn
        step(0, 0, 0, 0, 0);
        step(0, 0, 1, 1, 1);   // R8 edge beats ack
        step(0, 0, 1, 1, 0);
        step(0, 0, 1, 1, 0);
        step(0, 0, 1, 1, 1);   // R2
        step(0, 0, 0, 0, 0);
        step(0, 1, 1, 1, 0);   // R4 io_reset beats edge
        step(0, 0, 1, 1, 0);   // R4 history kept, no request
        step(0, 0, 0, 0, 0);
        step(0, 0, 1, 1, 0);   // R1
        step(0, 1, 1, 1, 0);   // R4 clears
        for (int i = 0; i < 3000; i++) begin
            logic r, ior, en, rdy, a;
            r   = ($urandom % 100) < 2;
            ior = ($urandom % 100) < 5;
            en  = ($urandom % 100) < 70;
            rdy = ($urandom % 100) < 60;
            a   = ($urandom % 100) < 20;
            step(r, ior, en, rdy, a);
        end
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule